// File: doc/BRIEF.md
# Two-Channel DMA Cycle Arbiter

This block picks the type of each machine-cycle slot on a shared bus. A slot is an instruction cycle, a DMA cycle for channel 0 or a DMA cycle for channel 1. Each channel has a transfer mode, a GO bit, source and destination addresses with address-space codes, and a demand function that depends on its mode. The serial receive and transmit flags, two external request flags and the transmit-FIFO not-full flag feed those demand functions.

Channel 0 normally wins over channel 1. Two structural hazards can override that order. First, a DMA write into the transmit FIFO must come straight after an instruction cycle. Second, an instruction cycle that touches a DMA control register is always followed by one more instruction cycle. The slot decision is stored in a three-state machine: `CY_INSTR`, `CY_DMA0` and `CY_DMA1`.

On every slot strobe the machine takes one of four named transitions:
- `T_IDLE` goes to `CY_INSTR` when no channel is eligible or a hazard blocks every requester.
- `T_GRANT0` goes to `CY_DMA0`.
- `T_GRANT1` goes to `CY_DMA1`.
- `T_HOLD` keeps the state when there is no strobe.

Top module: `dma_cycle_arbiter`

## Requirements
- R1: A synchronous active-high reset sets the slot type to instruction (`cyc_o` = 3'b001) and the grant to 2'b00. It also clears the alternate-cycle rotation so that channel 0 has the next turn.
- R2: The slot type changes only on a clock edge where `slot_en` is high. `grant_o` is high for exactly that one clock: bit 0 for a channel 0 DMA, bit 1 for a channel 1 DMA. `cyc_o` is one-hot: bit 0 instruction, bit 1 DMA0, bit 2 DMA1.
- R3: Mode codes are 00 alternate-cycles, 01 burst, 10 external-demand and 11 serial-demand. In external-demand mode, channel n has demand exactly when `ext_req[n]` and its GO bit are both set.
- R4: Space codes are 00 external data, 01 internal RAM, 10 special-function register, 11 reserved. In serial-demand mode, a channel has demand when its source is 0x99 in space 10 and `rx_flag` is set. Consecutive DMA cycles on this receive path are allowed.
- R5: In serial-demand mode, when the source test fails, a channel has demand when its destination is 0x99 in space 10 and `tx_flag` is set.
- R6: Address 0x99 in any space other than 10 never creates serial demand.
- R7: A channel with GO clear never gets a DMA cycle. A burst channel with GO set takes consecutive DMA cycles.
- R8: When both channels are eligible in the same slot, channel 0 is granted.
- R9: A channel whose destination is `TXF_ADDR` in space 10 is a transmit-FIFO channel. It has demand only while `txf_not_full` is high, and it is granted only in a slot that directly follows an instruction cycle.
- R10: A burst channel that does not write the transmit FIFO may take back-to-back cycles. Channel 1 is granted while channel 0 is blocked by the transmit-FIFO rule.
- R11: When an ending instruction slot has `dma_reg_acc` high, the next slot is an instruction cycle. The input has no effect when the ending slot is a DMA cycle.
- R12: An alternate-cycles channel is eligible only right after an instruction cycle. When both channels are in alternate-cycles mode with GO set, a channel is not eligible if it took the most recent DMA cycle, so the two channels take turns.
- R13: When no channel is eligible, the slot is an instruction cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_en | input | 1 | Slot boundary strobe |
| ch0_mode | input | 2 | Channel 0 transfer mode |
| ch0_go | input | 1 | Channel 0 GO bit |
| ch0_src | input | 16 | Channel 0 source address |
| ch0_src_sp | input | 2 | Channel 0 source space code |
| ch0_dst | input | 16 | Channel 0 destination address |
| ch0_dst_sp | input | 2 | Channel 0 destination space code |
| ch1_mode | input | 2 | Channel 1 transfer mode |
| ch1_go | input | 1 | Channel 1 GO bit |
| ch1_src | input | 16 | Channel 1 source address |
| ch1_src_sp | input | 2 | Channel 1 source space code |
| ch1_dst | input | 16 | Channel 1 destination address |
| ch1_dst_sp | input | 2 | Channel 1 destination space code |
| ext_req | input | 2 | External request flags, bit n for channel n |
| rx_flag | input | 1 | Serial receive flag |
| tx_flag | input | 1 | Serial transmit flag |
| txf_not_full | input | 1 | Transmit FIFO not full |
| dma_reg_acc | input | 1 | Current instruction slot accesses a DMA register |
| cyc_o | output | 3 | One-hot slot type {DMA1, DMA0, instruction} |
| grant_o | output | 2 | One-clock DMA grant pulse per channel |

## Verification
The assertions assume the following about the inputs:
- Reset is held high from time zero for at least one clock.
- Mode, address, flag and `dma_reg_acc` inputs are stable across the clock edge where `slot_en` is sampled. This is what makes the one-edge look-back checks on the transmit-FIFO hazard, the register-access gap and the channel 0 priority meaningful.
- `dma_reg_acc` describes the slot that is ending.

The bench changes every input only on the falling clock edge. It raises `slot_en` for exactly one clock per slot, so each decision sees one settled set of inputs.

// File: rtl/dcarb_pkg.sv
package dcarb_pkg;
    typedef enum logic [1:0] {
        MD_ALT   = 2'b00,
        MD_BURST = 2'b01,
        MD_EXT   = 2'b10,
        MD_SER   = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        SP_XDATA = 2'b00,
        SP_IRAM  = 2'b01,
        SP_SFR   = 2'b10,
        SP_RSVD  = 2'b11
    } addr_space_e;

    typedef enum logic [1:0] {
        CY_INSTR = 2'b00,
        CY_DMA0  = 2'b01,
        CY_DMA1  = 2'b10
    } cyc_state_e;

    localparam int NCH = 2;
endpackage

// File: rtl/dcarb_demand.sv
module dcarb_demand
    import dcarb_pkg::*;
#(
    parameter int             AW       = 16,
    parameter logic [AW-1:0]  SER_ADDR = 'h99,
    parameter logic [AW-1:0]  TXF_ADDR = 'h85
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode,
    input  logic          go,
    input  logic [AW-1:0] src,
    input  logic [1:0]    src_sp,
    input  logic [AW-1:0] dst,
    input  logic [1:0]    dst_sp,
    input  logic          ext_flag,
    input  logic          rx_flag,
    input  logic          tx_flag,
    input  logic          txf_nf,
    input  logic          other_alt_go,
    input  logic          last_was_instr,
    input  logic          last_dma_self,
    output logic          demand,
    output logic          tx_tgt
);
    logic src_hit, dst_hit, raw;

    always_comb begin
        src_hit = (src == SER_ADDR) && (addr_space_e'(src_sp) == SP_SFR);
        dst_hit = (dst == SER_ADDR) && (addr_space_e'(dst_sp) == SP_SFR);
        tx_tgt  = (dst == TXF_ADDR) && (addr_space_e'(dst_sp) == SP_SFR);
        unique case (xfer_mode_e'(mode))
            MD_ALT:   raw = last_was_instr && !(other_alt_go && last_dma_self);
            MD_BURST: raw = 1'b1;
            MD_EXT:   raw = ext_flag;
            MD_SER:   raw = (src_hit && rx_flag) || (!src_hit && dst_hit && tx_flag);
            default:  raw = 1'b0;
        endcase
        demand = go && raw && (!tx_tgt || txf_nf);
    end

    AST_RAM_NO_SER: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11) && (src_sp != 2'b10) && (dst_sp != 2'b10) |-> !demand); // R6
    AST_GO_GATE: assert property (@(posedge clk) disable iff (rst)
        !go |-> !demand); // R7
endmodule

// File: rtl/dcarb_fsm.sv
module dcarb_fsm
    import dcarb_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           slot_en,
    input  logic [NCH-1:0] dem,
    input  logic [NCH-1:0] tx_tgt,
    input  logic           dma_reg_acc,
    output logic [2:0]     cyc,
    output logic [NCH-1:0] grant,
    output logic           last_was_instr,
    output logic           last_dma
);
    cyc_state_e     state, nxt;
    logic [NCH-1:0] elig;
    logic           reg_block;

    assign reg_block = (state == CY_INSTR) && dma_reg_acc;

    for (genvar i = 0; i < NCH; i++) begin : g_elig
        assign elig[i] = dem[i] && !(tx_tgt[i] && state != CY_INSTR) && !reg_block;
    end

    // transitions: T_HOLD (no strobe), T_GRANT0, T_GRANT1, T_IDLE
    always_comb begin
        nxt = state;
        if (slot_en) begin
            if (elig[0])      nxt = CY_DMA0;
            else if (elig[1]) nxt = CY_DMA1;
            else              nxt = CY_INSTR;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= CY_INSTR;
            grant    <= '0;
            last_dma <= 1'b1;
        end else begin
            grant <= '0;
            if (slot_en) begin
                state <= nxt;
                grant <= {nxt == CY_DMA1, nxt == CY_DMA0};
                if (nxt == CY_DMA0) last_dma <= 1'b0;
                if (nxt == CY_DMA1) last_dma <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state)
            CY_INSTR: cyc = 3'b001;
            CY_DMA0:  cyc = 3'b010;
            CY_DMA1:  cyc = 3'b100;
            default:  cyc = 3'b001;
        endcase
        last_was_instr = (state == CY_INSTR);
    end

    AST_GRANT_ONE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R2
    AST_GRANT_ON_SLOT: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |-> $past(slot_en)); // R2
    AST_HOLD_NO_SLOT: assert property (@(posedge clk) disable iff (rst)
        !$past(slot_en) |-> $stable(state)); // R2
    AST_TX0_AFTER_INSTR: assert property (@(posedge clk) disable iff (rst)
        grant[0] && $past(tx_tgt[0]) |-> $past(state == CY_INSTR)); // R9
    AST_TX1_AFTER_INSTR: assert property (@(posedge clk) disable iff (rst)
        grant[1] && $past(tx_tgt[1]) |-> $past(state == CY_INSTR)); // R9
    AST_REG_GAP: assert property (@(posedge clk) disable iff (rst)
        $past(slot_en && state == CY_INSTR && dma_reg_acc) |-> (grant == '0)); // R11
    AST_CH0_FIRST: assert property (@(posedge clk) disable iff (rst)
        grant[1] && !$past(tx_tgt[0]) && !$past(dma_reg_acc) |-> !$past(dem[0])); // R8
endmodule

// File: rtl/dma_cycle_arbiter.sv
module dma_cycle_arbiter
    import dcarb_pkg::*;
#(
    parameter int             AW       = 16,
    parameter logic [AW-1:0]  SER_ADDR = 'h99,
    parameter logic [AW-1:0]  TXF_ADDR = 'h85
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          slot_en,
    input  logic [1:0]    ch0_mode,
    input  logic          ch0_go,
    input  logic [AW-1:0] ch0_src,
    input  logic [1:0]    ch0_src_sp,
    input  logic [AW-1:0] ch0_dst,
    input  logic [1:0]    ch0_dst_sp,
    input  logic [1:0]    ch1_mode,
    input  logic          ch1_go,
    input  logic [AW-1:0] ch1_src,
    input  logic [1:0]    ch1_src_sp,
    input  logic [AW-1:0] ch1_dst,
    input  logic [1:0]    ch1_dst_sp,
    input  logic [1:0]    ext_req,
    input  logic          rx_flag,
    input  logic          tx_flag,
    input  logic          txf_not_full,
    input  logic          dma_reg_acc,
    output logic [2:0]    cyc_o,
    output logic [1:0]    grant_o
);
    logic [1:0]    mode_a   [NCH];
    logic          go_a     [NCH];
    logic [AW-1:0] src_a    [NCH];
    logic [1:0]    srcsp_a  [NCH];
    logic [AW-1:0] dst_a    [NCH];
    logic [1:0]    dstsp_a  [NCH];
    logic [NCH-1:0] dem, tx_tgt, alt_go;
    logic           last_was_instr, last_dma;

    assign mode_a[0] = ch0_mode;   assign mode_a[1] = ch1_mode;
    assign go_a[0]   = ch0_go;     assign go_a[1]   = ch1_go;
    assign src_a[0]  = ch0_src;    assign src_a[1]  = ch1_src;
    assign srcsp_a[0]= ch0_src_sp; assign srcsp_a[1]= ch1_src_sp;
    assign dst_a[0]  = ch0_dst;    assign dst_a[1]  = ch1_dst;
    assign dstsp_a[0]= ch0_dst_sp; assign dstsp_a[1]= ch1_dst_sp;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign alt_go[i] = (xfer_mode_e'(mode_a[i]) == MD_ALT) && go_a[i];

        dcarb_demand #(.AW(AW), .SER_ADDR(SER_ADDR), .TXF_ADDR(TXF_ADDR)) u_dem (
            .clk            (clk),
            .rst            (rst),
            .mode           (mode_a[i]),
            .go             (go_a[i]),
            .src            (src_a[i]),
            .src_sp         (srcsp_a[i]),
            .dst            (dst_a[i]),
            .dst_sp         (dstsp_a[i]),
            .ext_flag       (ext_req[i]),
            .rx_flag        (rx_flag),
            .tx_flag        (tx_flag),
            .txf_nf         (txf_not_full),
            .other_alt_go   (alt_go[NCH-1-i]),
            .last_was_instr (last_was_instr),
            .last_dma_self  (last_dma == 1'(i)),
            .demand         (dem[i]),
            .tx_tgt         (tx_tgt[i])
        );
    end

    dcarb_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .slot_en        (slot_en),
        .dem            (dem),
        .tx_tgt         (tx_tgt),
        .dma_reg_acc    (dma_reg_acc),
        .cyc            (cyc_o),
        .grant          (grant_o),
        .last_was_instr (last_was_instr),
        .last_dma       (last_dma)
    );

    AST_CYC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(cyc_o) == 1); // R2
    AST_ALT_AFTER_INSTR: assert property (@(posedge clk) disable iff (rst)
        grant_o[0] && $past(ch0_mode == 2'b00) |-> $past(cyc_o[0])); // R12
endmodule

// File: tb/tb_dma_cycle_arbiter.sv
`timescale 1ns/1ps
module tb_dma_cycle_arbiter;
    localparam logic [2:0] CI = 3'b001, C0 = 3'b010, C1 = 3'b100;
    localparam logic [1:0] MALT = 2'b00, MBUR = 2'b01, MEXT = 2'b10, MSER = 2'b11;
    localparam logic [1:0] SIRAM = 2'b01, SSFR = 2'b10;

    logic clk = 0, rst = 1, slot_en = 0;
    logic [1:0] ch0_mode, ch1_mode, ch0_src_sp, ch0_dst_sp, ch1_src_sp, ch1_dst_sp, ext_req;
    logic ch0_go, ch1_go, rx_flag, tx_flag, txf_not_full, dma_reg_acc;
    logic [15:0] ch0_src, ch0_dst, ch1_src, ch1_dst;
    logic [2:0] cyc_o;
    logic [1:0] grant_o;
    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dma_cycle_arbiter dut (.*);

    task automatic chk(string req, logic [2:0] ec, logic [1:0] eg);
        n_run++;
        if (cyc_o !== ec || grant_o !== eg) begin
            n_fail++;
            $display("FAIL %s: cyc=%b grant=%b expected cyc=%b grant=%b", req, cyc_o, grant_o, ec, eg);
        end
    endtask

    task automatic clear_in;
        ch0_mode = MBUR; ch1_mode = MBUR; ch0_go = 0; ch1_go = 0;
        ch0_src = 16'h0030; ch0_dst = 16'h0040; ch1_src = 16'h0030; ch1_dst = 16'h0040;
        ch0_src_sp = SIRAM; ch0_dst_sp = SIRAM; ch1_src_sp = SIRAM; ch1_dst_sp = SIRAM;
        ext_req = 0; rx_flag = 0; tx_flag = 0; txf_not_full = 0; dma_reg_acc = 0;
    endtask

    task automatic do_reset;
        @(negedge clk); rst = 1; clear_in();
        @(negedge clk); @(negedge clk); rst = 0;
    endtask

    task automatic slot(string req, logic [2:0] ec, logic [1:0] eg);
        @(negedge clk); slot_en = 1;
        @(negedge clk); slot_en = 0;
        chk(req, ec, eg);
    endtask

    task automatic t_reset;
        do_reset(); chk("R1 reset state", CI, 2'b00);
    endtask

    task automatic t_ext;
        do_reset();
        ch0_mode = MEXT; ch1_mode = MEXT; ch0_go = 1; ch1_go = 1;
        slot("R13 no request idle", CI, 2'b00);
        ext_req = 2'b01; slot("R3 ext ch0", C0, 2'b01);
        ext_req = 2'b10; slot("R3 ext ch1", C1, 2'b10);
        ext_req = 2'b11; slot("R8 ch0 priority", C0, 2'b01);
    endtask

    task automatic t_hold;
        do_reset();
        ch0_go = 1;
        repeat (3) @(negedge clk);
        chk("R2 no slot no change", CI, 2'b00);
        slot("R2 grant on slot", C0, 2'b01);
        @(negedge clk);
        chk("R2 grant one clock", C0, 2'b00);
    endtask

    task automatic t_serial;
        do_reset();
        ch0_mode = MSER; ch0_go = 1;
        ch0_src = 16'h0099; ch0_src_sp = SSFR; rx_flag = 1;
        slot("R4 source receive", C0, 2'b01);
        slot("R4 receive back to back", C0, 2'b01);
        ch0_src_sp = SIRAM;
        slot("R6 source in RAM", CI, 2'b00);
        rx_flag = 0; ch0_dst = 16'h0099; ch0_dst_sp = SSFR; tx_flag = 1;
        slot("R5 dest transmit", C0, 2'b01);
        ch0_dst_sp = SIRAM;
        slot("R6 dest in RAM", CI, 2'b00);
        ch0_dst_sp = SSFR; tx_flag = 0;
        slot("R5 no transmit flag", CI, 2'b00);
    endtask

    task automatic t_go;
        do_reset();
        ch0_go = 1;
        slot("R7 burst first", C0, 2'b01);
        slot("R7 burst consecutive", C0, 2'b01);
        ch0_go = 0;
        slot("R7 GO cleared", CI, 2'b00);
    endtask

    task automatic t_tx;
        do_reset();
        ch0_go = 1; ch0_dst = 16'h0085; ch0_dst_sp = SSFR; txf_not_full = 1;
        slot("R9 tx after instr", C0, 2'b01);
        slot("R9 tx blocked after dma", CI, 2'b00);
        slot("R9 tx again", C0, 2'b01);
        txf_not_full = 0;
        slot("R9 fifo full", CI, 2'b00);
        slot("R9 fifo full stays", CI, 2'b00);
    endtask

    task automatic t_inv;
        do_reset();
        ch0_go = 1; ch0_dst = 16'h0085; ch0_dst_sp = SSFR; txf_not_full = 1;
        ch1_go = 1;
        slot("R8 both eligible", C0, 2'b01);
        slot("R10 ch1 ahead of blocked ch0", C1, 2'b10);
        slot("R10 ch1 consecutive", C1, 2'b10);
        ch1_go = 0;
        slot("R10 idle", CI, 2'b00);
        slot("R10 ch0 resumes", C0, 2'b01);
    endtask

    task automatic t_reg;
        do_reset();
        ch0_go = 1; dma_reg_acc = 1;
        slot("R11 forced instr", CI, 2'b00);
        dma_reg_acc = 0;
        slot("R11 dma after gap", C0, 2'b01);
        dma_reg_acc = 1;
        slot("R11 no effect in dma slot", C0, 2'b01);
    endtask

    task automatic t_alt;
        do_reset();
        ch0_mode = MALT; ch0_go = 1;
        slot("R12 alt first", C0, 2'b01);
        slot("R12 alt instr between", CI, 2'b00);
        slot("R12 alt again", C0, 2'b01);
        do_reset();
        ch0_mode = MALT; ch1_mode = MALT; ch0_go = 1; ch1_go = 1;
        slot("R12 both alt ch0", C0, 2'b01);
        slot("R12 both alt instr", CI, 2'b00);
        slot("R12 both alt ch1 turn", C1, 2'b10);
        slot("R12 both alt instr2", CI, 2'b00);
        slot("R12 both alt ch0 turn", C0, 2'b01);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        clear_in();
        t_reset();
        t_ext();
        t_hold();
        t_serial();
        t_go();
        t_tx();
        t_inv();
        t_reg();
        t_alt();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule